// File: doc/BRIEF.md
# Ring-Bus Loopback FIFO Peripheral

This block is a byte-wide target on a daisy-chained peripheral bus in which read data travels around a ring from the controller, through every peripheral and back. A peripheral that is not strobed must hand the incoming ring byte straight to its output, so the ring stays intact. When it is strobed, it serves ordinary register reads and writes, and it also answers poll cycles by reporting how many bytes it has waiting for the host.

Behind the bus sits a small register set: a loopback FIFO port (writes enqueue, reads dequeue), a read-only occupancy register, a scratch register, and a sticky capture of the periodic timing strobes that the system distributes (single-cycle pulses at fixed decades from 100 ns to 1 s). The acknowledge output doubles as flow control on the FIFO port. A push into a full queue or a pop from an empty one completes without acknowledge, which tells the controller where a burst stopped. A pop from a non-empty queue takes one stall cycle, which models a registered read path.

Top module: `ring_fifo_periph`

## Requirements
- R1: `data_out` equals `data_in` in every cycle where `strobe` is low, and in every strobed write cycle.
- R2: Address 2 is a scratch register that resets to 0x00, takes `data_in` on a write and returns the stored byte on a read, with `ack` high.
- R3: A tagged write to address 0 enqueues `data_in` and raises `ack` when the FIFO has room. When the FIFO holds `FIFO_DEPTH` bytes, the write keeps `ack` low and changes nothing.
- R4: A tagged read of address 0 on a non-empty FIFO holds `stall` high with `ack` low for exactly one cycle. In the next cycle it presents the oldest byte with `ack` high and dequeues it, so bytes leave in arrival order, including across pointer wrap.
- R5: A tagged read of address 0 on an empty FIFO completes in its first cycle with `stall` low, `ack` low and `data_out` 0x00.
- R6: Address 1 reads the FIFO occupancy, zero-extended, with `ack` high. Writes to it are acknowledged and have no effect.
- R7: A poll (strobe high, `wr_en` low, `addr_tag` low) returns the FIFO occupancy on `data_out` with `ack` high and no stall, for any address.
- R8: A strobed cycle with `wr_en` high and `addr_tag` low has no effect on any state, keeps `ack` low and passes `data_in` through.
- R9: Any address from 4 upward reads as 0x00 with `ack` high. Writes to such addresses are acknowledged and change nothing.
- R10: Address 3 reads a sticky OR of the `ticks` pulses seen since it was last read, and the read clears it. A pulse arriving in the same cycle as that read is kept for the next read.
- R11: `stall` and `ack` are never high together, and `stall` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | Bus cycle addressed to this peripheral |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr_tag | input | 1 | 1 = register access, 0 = poll |
| addr | input | ADDR_W (8) | Register address |
| data_in | input | DATA_W (8) | Ring data arriving from upstream |
| data_out | output | DATA_W (8) | Ring data leaving downstream |
| stall | output | 1 | More cycles needed before completion |
| ack | output | 1 | Access claimed and completed successfully |
| ticks | input | TICK_W (8) | Periodic single-cycle timing pulses |

## Verification
The bench builds the block with `FIFO_DEPTH` set to 5 and leaves the bus widths at their defaults. The depth of 5 is small enough that filling the queue and overrunning it takes a handful of writes. Because 5 is not a power of two, the explicit pointer wrap is exercised as well: a pop-push-drain sequence walks both pointers past the last slot. The tick capture is driven with pulses that arrive both before a read and during a read, so the clear-on-read race is covered.

// File: rtl/rbp_pkg.sv
// Package: shared constants and the access classification type for the
// ring-bus peripheral. Assumes register indices fit in the address width.
package rbp_pkg;

    // Implemented register indices; the FIFO port is index 0.
    localparam int RBP_IDX_FIFO    = 0;
    localparam int RBP_IDX_COUNT   = 1;
    localparam int RBP_IDX_SCRATCH = 2;
    localparam int RBP_IDX_TICKS   = 3;
    localparam int RBP_N_REGS      = 4;

    // Kind of bus cycle seen in the current clock.
    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_POLL,
        ACC_UNTAGGED_WR,
        ACC_REG_RD,
        ACC_REG_WR
    } rbp_acc_t;

endpackage

// File: rtl/rbp_decode.sv
// Module: rbp_decode
// Classifies the bus cycle from strobe, direction and tag, and decodes the
// address into one select line per implemented register. Purely
// combinational; assumes inputs are stable for the whole clock.
module rbp_decode
    import rbp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                  strobe,
    input  logic                  wr_en,
    input  logic                  addr_tag,
    input  logic [ADDR_W-1:0]     addr,
    output rbp_acc_t              kind,
    output logic [RBP_N_REGS-1:0] sel
);

    // Classify the access.
    always_comb begin
        if (!strobe)        kind = ACC_IDLE;
        else if (!addr_tag) kind = wr_en ? ACC_UNTAGGED_WR : ACC_POLL;
        else                kind = wr_en ? ACC_REG_WR : ACC_REG_RD;
    end

    // One comparator per implemented register.
    for (genvar i = 0; i < RBP_N_REGS; i++) begin : g_sel
        assign sel[i] = (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/rbp_fifo.sv
// Module: rbp_fifo
// Synchronous byte FIFO with occupancy count. Pointers wrap explicitly, so
// any depth of 2 or more works. Assumes the caller never pushes when full
// nor pops when empty (checked below).
module rbp_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic              full,
    output logic              empty
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    // Storage write; no reset needed for the data array.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    a_r3_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r4_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> count == $past(count) + 1'b1);

endmodule

// File: rtl/rbp_ticks.sv
// Module: rbp_ticks
// Sticky capture of periodic timing pulses. A clear wipes the old value,
// but pulses arriving in the clear cycle are kept. Assumes pulses last one
// clock.
module rbp_ticks #(
    parameter int TICK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TICK_W-1:0] ticks,
    input  logic              clear,
    output logic [TICK_W-1:0] seen
);

    // Accumulate pulses; clear-on-read loses none arriving in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= '0;
        else        seen <= (clear ? '0 : seen) | ticks;
    end

    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (seen & $past(seen)) == $past(seen));
    a_r10_new_pulse_kept: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> seen == $past(ticks));

endmodule

// File: rtl/ring_fifo_periph.sv
// Module: ring_fifo_periph
// Ring-bus target with a loopback FIFO port (index 0), occupancy (1),
// scratch (2) and tick capture (3). Unstrobed cycles pass ring data through.
// A non-empty FIFO read stalls one cycle. Assumes the controller holds the
// cycle's inputs stable until stall is low.
module ring_fifo_periph
    import rbp_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int TICK_W     = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              wr_en,
    input  logic              addr_tag,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              stall,
    output logic              ack,
    input  logic [TICK_W-1:0] ticks
);

    localparam int CNT_W = $clog2(FIFO_DEPTH+1);

    rbp_acc_t              kind;
    logic [RBP_N_REGS-1:0] sel;
    logic                  sel_known;
    logic [DATA_W-1:0]     head, rd_data_q, scratch_q, cnt_ext, ticks_ext;
    logic [CNT_W-1:0]      count;
    logic                  full, empty;
    logic                  rd_wait, fifo_rd, push, pop;
    logic [TICK_W-1:0]     seen;

    rbp_decode #(.ADDR_W(ADDR_W)) i_decode (
        .strobe(strobe), .wr_en(wr_en), .addr_tag(addr_tag), .addr(addr),
        .kind(kind), .sel(sel)
    );

    rbp_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .wdata(data_in), .pop(pop),
        .head(head), .count(count), .full(full), .empty(empty)
    );

    rbp_ticks #(.TICK_W(TICK_W)) i_ticks (
        .clk(clk), .rst_n(rst_n), .ticks(ticks),
        .clear(kind == ACC_REG_RD && sel[RBP_IDX_TICKS]), .seen(seen)
    );

    assign sel_known = |sel;
    assign cnt_ext   = DATA_W'(count);
    assign ticks_ext = DATA_W'(seen);

    // FIFO port control: stall once, then pop with acknowledge.
    assign fifo_rd = (kind == ACC_REG_RD) && sel[RBP_IDX_FIFO] && !empty;
    assign stall   = fifo_rd && !rd_wait;
    assign pop     = fifo_rd && rd_wait;
    assign push    = (kind == ACC_REG_WR) && sel[RBP_IDX_FIFO] && !full;

    // Track the stall phase of a FIFO read and capture the head byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_wait   <= 1'b0;
            rd_data_q <= '0;
        end else begin
            rd_wait <= stall;
            if (stall) rd_data_q <= head;
        end
    end

    // Scratch register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       scratch_q <= '0;
        else if (kind == ACC_REG_WR && sel[RBP_IDX_SCRATCH]) scratch_q <= data_in;
    end

    // Acknowledge generation per access kind.
    always_comb begin
        unique case (kind)
            ACC_POLL:   ack = 1'b1;
            ACC_REG_WR: ack = sel[RBP_IDX_FIFO] ? !full : 1'b1;
            ACC_REG_RD: ack = sel[RBP_IDX_FIFO] ? rd_wait : 1'b1;
            default:    ack = 1'b0;
        endcase
    end

    // Ring data output: pass-through unless a read supplies data.
    always_comb begin
        data_out = data_in;
        if (kind == ACC_POLL) begin
            data_out = cnt_ext;
        end else if (kind == ACC_REG_RD) begin
            if (!sel_known)                 data_out = '0;
            else if (sel[RBP_IDX_FIFO])     data_out = rd_wait ? rd_data_q :
                                                       (empty ? '0 : data_in);
            else if (sel[RBP_IDX_COUNT])    data_out = cnt_ext;
            else if (sel[RBP_IDX_SCRATCH])  data_out = scratch_q;
            else                            data_out = ticks_ext;
        end
    end

    a_r1_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe || wr_en) |-> data_out == data_in);
    a_r11_stall_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !ack);
    a_r11_single_stall: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
    a_r7_poll_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !wr_en && !addr_tag) |-> (ack && !stall && data_out == cnt_ext));
    a_r8_untagged_write_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && wr_en && !addr_tag) |-> !ack);
    a_r8_untagged_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && wr_en && !addr_tag) |=> ($stable(count) && $stable(scratch_q)));
    a_r2_scratch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && wr_en && addr_tag && addr == ADDR_W'(RBP_IDX_SCRATCH))
        |=> $stable(scratch_q));
    a_r5_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !wr_en && addr_tag && addr == '0 && empty && !rd_wait)
        |-> (!ack && !stall && data_out == '0));

endmodule

// File: tb/test_ring_fifo_periph.sv
// Scoreboard bench: the driver queues the expected reply of each bus cycle,
// and a monitor compares every completed cycle against the queue front.
module test_ring_fifo_periph;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0, wr_en = 1'b0, addr_tag = 1'b0;
    logic [7:0] addr = '0, data_in = '0, ticks = '0;
    logic [7:0] data_out;
    logic       stall, ack;

    int n_chk = 0, n_fail = 0;
    logic [7:0] exp_data_q [$];
    logic       exp_ack_q  [$];
    string      exp_req_q  [$];
    logic [7:0] model_q    [$];

    always #5 clk = ~clk;

    ring_fifo_periph #(.FIFO_DEPTH(5)) i_ring_fifo_periph (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .wr_en(wr_en),
        .addr_tag(addr_tag), .addr(addr), .data_in(data_in),
        .data_out(data_out), .stall(stall), .ack(ack), .ticks(ticks)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Monitor: compare each completed strobed cycle with the scoreboard.
    always @(negedge clk) begin
        if (rst_n && strobe && !stall) begin
            if (exp_data_q.size() == 0) begin
                chk(1'b0, "scoreboard underrun", 0, 1);
            end else begin
                logic [7:0] ed;
                logic       ea;
                string      rq;
                ed = exp_data_q.pop_front();
                ea = exp_ack_q.pop_front();
                rq = exp_req_q.pop_front();
                chk(data_out == ed, {rq, " data"}, data_out, ed);
                chk(ack == ea, {rq, " ack"}, ack, ea);
            end
        end
    end

    // Driver: one bus cycle, held until stall is low, then released.
    task automatic bus(input bit we, input bit tag, input logic [7:0] a,
                       input logic [7:0] d, input logic [7:0] tk,
                       input logic [7:0] ed, input bit ea, input int es,
                       input string req);
        int stalls = 0;
        exp_data_q.push_back(ed);
        exp_ack_q.push_back(ea);
        exp_req_q.push_back(req);
        @(posedge clk); #1;
        strobe = 1'b1; wr_en = we; addr_tag = tag; addr = a; data_in = d; ticks = tk;
        forever begin
            @(negedge clk);
            if (!stall) break;
            stalls++;
            chk(ack == 1'b0, "R11 ack during stall", ack, 0);
        end
        chk(stalls == es, {req, " stall cycles"}, stalls, es);
        @(posedge clk); #1;
        strobe = 1'b0; ticks = '0;
    endtask

    task automatic idle_chk(input logic [7:0] d);
        @(posedge clk); #1;
        strobe = 1'b0; data_in = d;
        @(negedge clk);
        chk(data_out == d, "R1 passthrough idle", data_out, d);
    endtask

    task automatic push_b(input logic [7:0] d);
        bit ok = (model_q.size() < 5);
        if (ok) model_q.push_back(d);
        bus(1, 1, 8'h00, d, 8'h00, d, ok, 0, ok ? "R3 push" : "R3 push full");
    endtask

    task automatic pop_b();
        if (model_q.size() == 0) begin
            bus(0, 1, 8'h00, 8'h6B, 8'h00, 8'h00, 1'b0, 0, "R5 pop empty");
        end else begin
            logic [7:0] v = model_q.pop_front();
            bus(0, 1, 8'h00, 8'h6B, 8'h00, v, 1'b1, 1, "R4 pop");
        end
    endtask

    task automatic poll_b();
        bus(0, 0, 8'h00, 8'h33, 8'h00, 8'(model_q.size()), 1'b1, 0, "R7 poll");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_test();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state and pass-through.
        idle_chk(8'h3C);
        idle_chk(8'hC3);
        poll_b();
        bus(0, 1, 8'h01, 8'h00, 8'h00, 8'h00, 1, 0, "R6 count after reset");
        bus(0, 1, 8'h02, 8'h00, 8'h00, 8'h00, 1, 0, "R2 scratch reset");

        // Scratch register.
        bus(1, 1, 8'h02, 8'hA5, 8'h00, 8'hA5, 1, 0, "R2 scratch write R1");
        bus(0, 1, 8'h02, 8'h11, 8'h00, 8'hA5, 1, 0, "R2 scratch read");

        // Empty read, fill, overflow.
        pop_b();
        for (int i = 0; i < 5; i++) push_b(8'h10 + 8'(i));
        push_b(8'hEE);
        poll_b();
        bus(0, 1, 8'h01, 8'h00, 8'h00, 8'h05, 1, 0, "R6 count full");
        bus(1, 1, 8'h01, 8'h77, 8'h00, 8'h77, 1, 0, "R6 count write");
        bus(0, 1, 8'h01, 8'h00, 8'h00, 8'h05, 1, 0, "R6 count unchanged");

        // Untagged write is inert.
        bus(1, 0, 8'h02, 8'h99, 8'h00, 8'h99, 0, 0, "R8 untagged write");
        poll_b();
        bus(0, 1, 8'h02, 8'h00, 8'h00, 8'hA5, 1, 0, "R8 scratch untouched");

        // Order across pointer wrap.
        pop_b(); pop_b();
        push_b(8'h20); push_b(8'h21);
        poll_b();
        for (int i = 0; i < 5; i++) pop_b();
        pop_b();
        poll_b();
        push_b(8'h30);
        idle_chk(8'h5E);
        pop_b();

        // Unimplemented addresses.
        bus(0, 1, 8'h80, 8'h44, 8'h00, 8'h00, 1, 0, "R9 read unimpl");
        bus(1, 1, 8'hFF, 8'h5A, 8'h00, 8'h5A, 1, 0, "R9 write unimpl");
        bus(1, 1, 8'h04, 8'h5B, 8'h00, 8'h5B, 1, 0, "R9 write unimpl low");
        bus(0, 1, 8'h02, 8'h00, 8'h00, 8'hA5, 1, 0, "R9 scratch untouched");
        bus(0, 1, 8'h04, 8'h00, 8'h00, 8'h00, 1, 0, "R9 read addr 4");
        poll_b();

        // Tick capture.
        @(posedge clk); #1 ticks = 8'h05;
        @(posedge clk); #1 ticks = 8'h00;
        @(posedge clk); #1 ticks = 8'h40;
        @(posedge clk); #1 ticks = 8'h00;
        bus(0, 1, 8'h03, 8'h00, 8'h00, 8'h45, 1, 0, "R10 ticks sticky");
        bus(0, 1, 8'h03, 8'h00, 8'h10, 8'h00, 1, 0, "R10 ticks cleared");
        bus(0, 1, 8'h03, 8'h00, 8'h00, 8'h10, 1, 0, "R10 same-cycle pulse kept");
        bus(0, 1, 8'h03, 8'h00, 8'h00, 8'h00, 1, 0, "R10 cleared again");

        repeat (3) @(posedge clk);
        chk(exp_data_q.size() == 0, "scoreboard drained", exp_data_q.size(), 0);
        finish_test();
    end

endmodule